// File: doc/BRIEF.md
# Parallel NOR Flash Block Programming Sequencer

This controller writes a run of bytes into an asynchronous parallel NOR flash. The host gives it a start address, a byte count and a mode bit, then pulses `start`. The sequencer pulls each byte over a valid/ready handshake and reads the target location first, refusing any byte that would need a bit to go from 0 back to 1. It then issues the flash's program command writes and polls the status byte at the target until the embedded program finishes. A final read of the byte decides whether it advances to the next address or stops.

With the mode bit set, the sequencer first puts the flash into unlock bypass mode. In that mode every byte costs two command writes instead of four. Before it reports completion it takes the flash back out of bypass, and it does so even after a failure. The result is a one-cycle `done` pulse, together with a `fail` flag and the address of the byte that failed. Both stay readable until the next start.

Each flash bus cycle takes exactly one clock. The flash read data is sampled on the clock edge that ends a read cycle.

Top module: `fps_top`

## Requirements
- R1: In standard mode each byte is written with four writes in this order: (UNLK_A1=555h, AAh), (UNLK_A2=2AAh, 55h), (555h, A0h), then (target address, data).
- R2: In bypass mode the block begins with entry writes (555h, AAh), (2AAh, 55h), (555h, 20h). Each byte then takes two writes: (555h, A0h) followed by (target, data). The block ends with exit writes (555h, 90h) and (555h, 00h), issued after the last byte or after a failure.
- R3: `in_ready` is high only while the sequencer waits for the next byte, and a byte is taken on a cycle with `in_valid` and `in_ready` both high. Bytes go to consecutive addresses starting at `start_addr`.
- R4: Before any command write for a byte, the target is read. If a bit is 0 in the flash but 1 in the data, the sequencer fails at that address and issues no write for that byte.
- R5: After the data write, status is read at the target until status bit 7 equals data bit 7. Only then is the verify read made.
- R6: If a status read has bit 7 unequal to the data and bit 5 set, exactly one more status read follows. If bit 7 still differs on that read, the sequence fails.
- R7: After POLL_MAX status reads without completion, the sequence fails.
- R8: If the verify read differs from the data, the sequence fails, `fail_addr` holds that byte's address, and no further byte is fetched.
- R9: `done` is a single-cycle pulse. `fail` and `fail_addr` hold their values until the next accepted start, which clears `fail`.
- R10: A start with `byte_count` of 0 produces `done` on the next cycle, with no flash cycle and `fail` low.
- R11: The synchronous active-low reset returns the block to idle, with `busy`, `done` and `fail` low and no strobes. A start after a reset issues the full command sequence for the byte from its first unlock write.
- R12: `start` is ignored while `busy` is high.
- R13: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a block (sampled when idle) |
| bypass_en | input | 1 | Use unlock bypass mode for this block |
| start_addr | input | ADDR_W | First flash address |
| byte_count | input | CNT_W | Number of bytes to program |
| in_valid | input | 1 | Source byte available |
| in_ready | output | 1 | Sequencer takes a byte this cycle |
| in_data | input | 8 | Source byte |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write cycle |
| fl_re | output | 1 | Flash read cycle |
| fl_rdata | input | 8 | Flash read data, sampled at the end of a read cycle |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| fail | output | 1 | The last block failed |
| fail_addr | output | ADDR_W | Address of the failing byte |

## Verification
The bench runs the main loop against a behavioural flash in two modes. In standard mode it programs several bytes across mixed bit patterns. In bypass mode it programs a second run, which separates the four-write and two-write command shapes, and shows that bypass entry and exit bracket the run. A byte whose target already holds zeros where the data has ones checks that the pre-check fires without a single write. Three injected flash faults each end a run through a different failure path: a corrupted cell caught at verify, a stuck device with bit 5 set caught by the single re-read, and a stuck device without bit 5 caught by the poll limit. Read counts at the ports keep these three paths apart.

// File: rtl/fps_pkg.sv
// Shared types and command bytes for the flash programming sequencer.
// Assumes a byte-wide flash whose command set uses the unlock pair and
// the program / bypass command values listed below.
package fps_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_ENTER, S_FETCH, S_PRECHK, S_CMD,
        S_POLL, S_POLL2, S_VERIFY, S_WRAP, S_EXIT, S_FINISH
    } fps_state_e;

    typedef enum logic [1:0] {
        SEQ_ENTER, SEQ_STD, SEQ_BYP, SEQ_EXIT
    } fps_seq_e;

    typedef enum logic [1:0] {
        PR_BUSY, PR_DONE, PR_FAULT
    } fps_poll_e;

    localparam logic [7:0] CMD_KEY1     = 8'hAA;
    localparam logic [7:0] CMD_KEY2     = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_BYP_IN   = 8'h20;
    localparam logic [7:0] CMD_BYP_OUT1 = 8'h90;
    localparam logic [7:0] CMD_BYP_OUT2 = 8'h00;

endpackage

// File: rtl/fps_step_gen.sv
// Command write generator: maps a sequence kind and step index to the
// address/data of one flash write, and flags the last step of the kind.
// Assumes the controller walks steps from 0 upward one per clock.
module fps_step_gen
    import fps_pkg::*;
#(
    parameter int unsigned         ADDR_W  = 17,
    parameter logic [ADDR_W-1:0]   UNLK_A1 = ADDR_W'('h555),
    parameter logic [ADDR_W-1:0]   UNLK_A2 = ADDR_W'('h2AA)
) (
    input  fps_seq_e            seq,
    input  logic [1:0]          step,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic [7:0]          tgt_data,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [7:0]          wr_data,
    output logic                seq_last
);

    // Select the write for the current step of the current sequence.
    always_comb begin
        wr_addr  = UNLK_A1;
        wr_data  = CMD_KEY1;
        seq_last = 1'b0;
        unique case (seq)
            SEQ_ENTER: begin
                unique case (step)
                    2'd0:    wr_data = CMD_KEY1;
                    2'd1:    begin wr_addr = UNLK_A2; wr_data = CMD_KEY2; end
                    default: begin wr_data = CMD_BYP_IN; seq_last = 1'b1; end
                endcase
            end
            SEQ_STD: begin
                unique case (step)
                    2'd0:    wr_data = CMD_KEY1;
                    2'd1:    begin wr_addr = UNLK_A2; wr_data = CMD_KEY2; end
                    2'd2:    wr_data = CMD_PROGRAM;
                    default: begin
                        wr_addr  = tgt_addr;
                        wr_data  = tgt_data;
                        seq_last = 1'b1;
                    end
                endcase
            end
            SEQ_BYP: begin
                if (step == 2'd0) begin
                    wr_data = CMD_PROGRAM;
                end else begin
                    wr_addr  = tgt_addr;
                    wr_data  = tgt_data;
                    seq_last = 1'b1;
                end
            end
            default: begin
                if (step == 2'd0) begin
                    wr_data = CMD_BYP_OUT1;
                end else begin
                    wr_data  = CMD_BYP_OUT2;
                    seq_last = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/fps_addr_ctr.sv
// Address and remaining-count register pair for the block being written.
// Assumes load and advance are never requested in the same cycle.
module fps_addr_ctr #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned CNT_W  = ADDR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [CNT_W-1:0]    ld_cnt,
    input  logic                adv,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic                is_last
);

    logic [CNT_W-1:0] remain;

    // Hold the current target and count down the bytes still to write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            remain   <= ld_cnt;
        end else if (adv) begin
            cur_addr <= cur_addr + 1'b1;
            remain   <= remain - 1'b1;
        end
    end

    // The byte in hand is the final one when a single byte remains.
    always_comb is_last = (remain == CNT_W'(1));

endmodule

// File: rtl/fps_poll_eval.sv
// Classifies one status read taken during an embedded program.
// Assumes bit 7 carries the complement of the written bit 7 while busy
// and bit 5 reports an exceeded internal time limit.
module fps_poll_eval
    import fps_pkg::*;
(
    input  logic       st_b7,
    input  logic       st_b5,
    input  logic       exp_b7,
    output fps_poll_e  result
);

    // Completion wins over the fault bit; the fault bit alone asks for a re-read.
    always_comb begin
        if (st_b7 == exp_b7)
            result = PR_DONE;
        else if (st_b5)
            result = PR_FAULT;
        else
            result = PR_BUSY;
    end

endmodule

// File: rtl/fps_top.sv
// Flash block programming sequencer. Fetches bytes over a valid/ready
// handshake, pre-checks, programs, data-polls and verifies each one, with
// an optional unlock bypass wrap. Assumes one flash bus cycle per clock
// and read data valid at the edge that ends the read cycle.
module fps_top
    import fps_pkg::*;
#(
    parameter int unsigned         ADDR_W   = 17,
    parameter int unsigned         CNT_W    = ADDR_W + 1,
    parameter int unsigned         POLL_MAX = 4096,
    parameter logic [ADDR_W-1:0]   UNLK_A1  = ADDR_W'('h555),
    parameter logic [ADDR_W-1:0]   UNLK_A2  = ADDR_W'('h2AA)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                bypass_en,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [CNT_W-1:0]    byte_count,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [7:0]          in_data,
    output logic [ADDR_W-1:0]   fl_addr,
    output logic [7:0]          fl_wdata,
    output logic                fl_we,
    output logic                fl_re,
    input  logic [7:0]          fl_rdata,
    output logic                busy,
    output logic                done,
    output logic                fail,
    output logic [ADDR_W-1:0]   fail_addr
);

    localparam int unsigned PCW = $clog2(POLL_MAX + 1);
    localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_MAX - 1);

    fps_state_e           st;
    logic [1:0]           step;
    logic                 byp_act;
    logic [7:0]           data_q;
    logic [PCW-1:0]       poll_cnt;
    logic                 fail_q;
    logic [ADDR_W-1:0]    fail_addr_q;

    logic                 ctr_load, ctr_adv, is_last;
    logic [ADDR_W-1:0]    cur_addr;
    fps_seq_e             seq;
    logic [ADDR_W-1:0]    wr_addr;
    logic [7:0]           wr_data;
    logic                 seq_last;
    fps_poll_e            pres;
    logic                 set_bits, vfy_ok;

    fps_addr_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .ld_addr  (start_addr),
        .ld_cnt   (byte_count),
        .adv      (ctr_adv),
        .cur_addr (cur_addr),
        .is_last  (is_last)
    );

    fps_step_gen #(.ADDR_W(ADDR_W), .UNLK_A1(UNLK_A1), .UNLK_A2(UNLK_A2)) u_gen (
        .seq      (seq),
        .step     (step),
        .tgt_addr (cur_addr),
        .tgt_data (data_q),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .seq_last (seq_last)
    );

    fps_poll_eval u_poll (
        .st_b7  (fl_rdata[7]),
        .st_b5  (fl_rdata[5]),
        .exp_b7 (data_q[7]),
        .result (pres)
    );

    // Pick the command sequence that the current state walks through.
    always_comb begin
        unique case (st)
            S_ENTER: seq = SEQ_ENTER;
            S_EXIT:  seq = SEQ_EXIT;
            default: seq = byp_act ? SEQ_BYP : SEQ_STD;
        endcase
    end

    // Decode read results and counter controls.
    always_comb begin
        set_bits = |(~fl_rdata & data_q);
        vfy_ok   = (fl_rdata == data_q);
        ctr_load = (st == S_IDLE) && start;
        ctr_adv  = (st == S_VERIFY) && vfy_ok && !is_last;
    end

    // Drive the flash bus and the host-side outputs from the state.
    always_comb begin
        fl_we     = (st == S_ENTER) || (st == S_CMD) || (st == S_EXIT);
        fl_re     = (st == S_PRECHK) || (st == S_POLL) ||
                    (st == S_POLL2) || (st == S_VERIFY);
        fl_addr   = fl_we ? wr_addr : cur_addr;
        fl_wdata  = fl_we ? wr_data : 8'h00;
        in_ready  = (st == S_FETCH);
        busy      = (st != S_IDLE);
        done      = (st == S_FINISH);
        fail      = fail_q;
        fail_addr = fail_addr_q;
    end

    // Main sequencer: one flash bus cycle per state visit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            step        <= 2'd0;
            byp_act     <= 1'b0;
            data_q      <= 8'h00;
            poll_cnt    <= '0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        fail_q <= 1'b0;
                        step   <= 2'd0;
                        if (byte_count == '0)
                            st <= S_FINISH;
                        else if (bypass_en)
                            st <= S_ENTER;
                        else
                            st <= S_FETCH;
                    end
                end
                S_ENTER: begin
                    if (seq_last) begin
                        byp_act <= 1'b1;
                        step    <= 2'd0;
                        st      <= S_FETCH;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                S_FETCH: begin
                    if (in_valid) begin
                        data_q <= in_data;
                        st     <= S_PRECHK;
                    end
                end
                S_PRECHK: begin
                    if (set_bits) begin
                        fail_q      <= 1'b1;
                        fail_addr_q <= cur_addr;
                        st          <= S_WRAP;
                    end else begin
                        step <= 2'd0;
                        st   <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (seq_last) begin
                        step     <= 2'd0;
                        poll_cnt <= '0;
                        st       <= S_POLL;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                S_POLL: begin
                    unique case (pres)
                        PR_DONE:  st <= S_VERIFY;
                        PR_FAULT: st <= S_POLL2;
                        default: begin
                            if (poll_cnt == POLL_LAST) begin
                                fail_q      <= 1'b1;
                                fail_addr_q <= cur_addr;
                                st          <= S_WRAP;
                            end else begin
                                poll_cnt <= poll_cnt + 1'b1;
                            end
                        end
                    endcase
                end
                S_POLL2: begin
                    if (pres == PR_DONE) begin
                        st <= S_VERIFY;
                    end else begin
                        fail_q      <= 1'b1;
                        fail_addr_q <= cur_addr;
                        st          <= S_WRAP;
                    end
                end
                S_VERIFY: begin
                    if (!vfy_ok) begin
                        fail_q      <= 1'b1;
                        fail_addr_q <= cur_addr;
                        st          <= S_WRAP;
                    end else if (is_last) begin
                        st <= S_WRAP;
                    end else begin
                        st <= S_FETCH;
                    end
                end
                S_WRAP: begin
                    step <= 2'd0;
                    st   <= byp_act ? S_EXIT : S_FINISH;
                end
                S_EXIT: begin
                    if (seq_last) begin
                        byp_act <= 1'b0;
                        st      <= S_FINISH;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fps_chk.sv
// Port-level protocol checker for fps_top, attached by bind below.
module fps_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned CNT_W  = ADDR_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [CNT_W-1:0]   byte_count,
    input logic               in_ready,
    input logic               fl_we,
    input logic               fl_re,
    input logic               busy,
    input logic               done,
    input logic               fail,
    input logic [ADDR_W-1:0]  fail_addr
);

    AST_EXCL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re)); // R13
    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && !fl_we && !fl_re)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(fail) && $stable(fail_addr))); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_we && !fl_re)); // R11
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !fail)); // R11
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R12
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && byte_count == '0) |=> (done && !fail)); // R10

endmodule

bind fps_top fps_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_count (byte_count),
    .in_ready   (in_ready),
    .fl_we      (fl_we),
    .fl_re      (fl_re),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fail_addr  (fail_addr)
);

// File: tb/sim_fps_top.sv
// Scoreboard bench: driver tasks queue expected flash writes, a monitor
// compares every write strobe; a behavioural flash answers reads.
module sim_fps_top;
    localparam int AW  = 11;
    localparam int CW  = 12;
    localparam int PM  = 16;
    localparam int LAT = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, bypass_en = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, fl_we, fl_re, busy, done, fail;
    logic [AW-1:0] fl_addr, fail_addr;
    logic [7:0] fl_wdata, fl_rdata;

    fps_top #(.ADDR_W(AW), .CNT_W(CW), .POLL_MAX(PM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bypass_en(bypass_en),
        .start_addr(start_addr), .byte_count(byte_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr)
    );

    // ---------------- behavioural flash ----------------
    logic [7:0] mem [0:(1<<AW)-1];
    logic [1:0] ul = 2'd0;
    logic armed = 1'b0, byp = 1'b0, ex1 = 1'b0, pb = 1'b0, tog = 1'b0;
    logic [AW-1:0] pa = '0;
    logic [7:0] pd = 8'h00;
    int pcnt = 0;
    bit inj_corrupt = 0, inj_stuck = 0, inj_dq5 = 0;

    assign fl_rdata = pb ? {~pd[7], tog, inj_dq5, 5'b0} : mem[fl_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            ul <= 2'd0; armed <= 1'b0; byp <= 1'b0; ex1 <= 1'b0; pb <= 1'b0;
        end else begin
            if (fl_re) tog <= ~tog;
            if (pb) begin
                if (!inj_stuck && !inj_dq5) begin
                    if (pcnt <= 1) begin
                        pb <= 1'b0;
                        mem[pa] <= mem[pa] & pd & (inj_corrupt ? 8'hFE : 8'hFF);
                    end else pcnt <= pcnt - 1;
                end
            end else if (fl_we) begin
                if (armed) begin
                    armed <= 1'b0; pb <= 1'b1; pa <= fl_addr; pd <= fl_wdata;
                    pcnt <= LAT; ul <= 2'd0;
                end else if (byp) begin
                    if (ex1) begin
                        ex1 <= 1'b0;
                        if (fl_wdata == 8'h00) byp <= 1'b0;
                    end else if (fl_wdata == 8'hA0) armed <= 1'b1;
                    else if (fl_wdata == 8'h90) ex1 <= 1'b1;
                end else if (ul == 2'd0) begin
                    ul <= (fl_addr == 11'h555 && fl_wdata == 8'hAA) ? 2'd1 : 2'd0;
                end else if (ul == 2'd1) begin
                    ul <= (fl_addr == 11'h2AA && fl_wdata == 8'h55) ? 2'd2 : 2'd0;
                end else begin
                    ul <= 2'd0;
                    if (fl_addr == 11'h555 && fl_wdata == 8'hA0) armed <= 1'b1;
                    else if (fl_addr == 11'h555 && fl_wdata == 8'h20) byp <= 1'b1;
                end
            end
        end
    end

    // ---------------- byte source ----------------
    logic [7:0] byte_q[$];
    logic took = 1'b0;
    always @(posedge clk) took <= in_valid && in_ready;
    always @(negedge clk) begin
        if (took && byte_q.size() > 0) void'(byte_q.pop_front());
        in_valid = (byte_q.size() > 0);
        in_data  = (byte_q.size() > 0) ? byte_q[0] : 8'h00;
    end

    // ---------------- scoreboard ----------------
    typedef struct { logic [AW-1:0] a; logic [7:0] d; int r; } wr_t;
    wr_t exp_q[$];
    bit sb_on = 1;
    int n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_w(input logic [AW-1:0] a, input logic [7:0] d, input int r);
        wr_t w;
        w.a = a; w.d = d; w.r = r;
        exp_q.push_back(w);
    endtask

    task automatic exp_std(input logic [AW-1:0] a, input logic [7:0] d); // R1
        push_w(11'h555, 8'hAA, 1); push_w(11'h2AA, 8'h55, 1);
        push_w(11'h555, 8'hA0, 1); push_w(a, d, 1);
    endtask
    task automatic exp_entry(); // R2
        push_w(11'h555, 8'hAA, 2); push_w(11'h2AA, 8'h55, 2); push_w(11'h555, 8'h20, 2);
    endtask
    task automatic exp_byp(input logic [AW-1:0] a, input logic [7:0] d); // R2
        push_w(11'h555, 8'hA0, 2); push_w(a, d, 2);
    endtask
    task automatic exp_exit(); // R2
        push_w(11'h555, 8'h90, 2); push_w(11'h555, 8'h00, 2);
    endtask

    // Monitor: compare every write strobe with the head of the queue.
    always @(negedge clk) begin
        wr_t e;
        if (fl_re) rd_cnt++;
        if (fl_we) begin
            wr_cnt++;
            if (sb_on) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R1/R2", "unexpected write", {fl_addr, fl_wdata}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(fl_addr == e.a && fl_wdata == e.d, $sformatf("R%0d", e.r),
                        "write", {fl_addr, fl_wdata}, {e.a, e.d});
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 1);
        summary();
    end

    task automatic kick(input logic [AW-1:0] a, input int cnt, input bit bp);
        @(negedge clk);
        start_addr = a; byte_count = CW'(cnt); bypass_en = bp; start = 1'b1;
        rd_cnt = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (!done && g < 5000) begin @(negedge clk); g++; end
    endtask

    task automatic hw_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!busy && !done && !fail, "R11", "reset busy/done/fail", {busy, done, fail}, 0);
        chk(!fl_we && !fl_re && !in_ready, "R11", "reset strobes", {fl_we, fl_re, in_ready}, 0);
        rst_n = 1'b1;

        // R1 R3 R5 R12: standard mode, three bytes, stray start while busy
        byte_q = '{8'h12, 8'h34, 8'hF0};
        exp_std(11'h010, 8'h12); exp_std(11'h011, 8'h34); exp_std(11'h012, 8'hF0);
        kick(11'h010, 3, 0);
        repeat (6) @(negedge clk);
        start_addr = 11'h7F0; bypass_en = 1'b1; start = 1'b1; // R12
        @(negedge clk); start = 1'b0;
        wait_done();
        chk(done && !fail, "R5", "standard block result", {done, fail}, 2);
        chk(exp_q.size() == 0, "R1", "writes left", exp_q.size(), 0);
        chk(mem[11'h010] == 8'h12 && mem[11'h011] == 8'h34 && mem[11'h012] == 8'hF0,
            "R3", "programmed bytes", mem[11'h011], 8'h34);
        @(negedge clk);
        chk(!done, "R9", "done pulse width", done, 0);

        // R2: bypass mode, three bytes
        byte_q = '{8'hA5, 8'h00, 8'h7E};
        exp_entry(); exp_byp(11'h100, 8'hA5); exp_byp(11'h101, 8'h00);
        exp_byp(11'h102, 8'h7E); exp_exit();
        kick(11'h100, 3, 1);
        wait_done();
        chk(!fail && exp_q.size() == 0, "R2", "bypass block", exp_q.size(), 0);
        chk(mem[11'h100] == 8'hA5 && mem[11'h101] == 8'h00 && mem[11'h102] == 8'h7E,
            "R2", "bypass bytes", mem[11'h102], 8'h7E);

        // R10: zero count
        kick(11'h050, 0, 1);
        chk(done && !fail, "R10", "zero count done", {done, fail}, 2);
        chk(rd_cnt == 0, "R10", "zero count reads", rd_cnt, 0);

        // R4: pre-check rejects a 0->1 byte, no writes for it
        mem[11'h200] = 8'h0F;
        byte_q = '{8'hAB, 8'hF0};
        exp_std(11'h1FF, 8'hAB);
        kick(11'h1FF, 2, 0);
        wait_done();
        chk(fail && fail_addr == 11'h200, "R4", "pre-check fail addr", fail_addr, 11'h200);
        chk(mem[11'h200] == 8'h0F && exp_q.size() == 0, "R4", "cell untouched", mem[11'h200], 8'h0F);
        repeat (3) @(negedge clk);
        chk(fail && fail_addr == 11'h200, "R9", "fail held while idle", fail_addr, 11'h200);

        // R8: verify mismatch in bypass mode, exit still issued
        inj_corrupt = 1;
        byte_q = '{8'h55, 8'h66};
        exp_entry(); exp_byp(11'h400, 8'h55); exp_exit();
        kick(11'h400, 2, 1);
        wait_done();
        chk(fail && fail_addr == 11'h400, "R8", "verify fail addr", fail_addr, 11'h400);
        chk(exp_q.size() == 0 && byte_q.size() == 1, "R8", "stopped after fail", byte_q.size(), 1);
        inj_corrupt = 0; byte_q.delete();

        // R6: bit 5 fault, one re-read then fail
        inj_dq5 = 1;
        byte_q = '{8'h80};
        exp_std(11'h500, 8'h80);
        kick(11'h500, 1, 0);
        wait_done();
        chk(fail && fail_addr == 11'h500, "R6", "fault fail addr", fail_addr, 11'h500);
        chk(rd_cnt == 3, "R6", "reads on fault", rd_cnt, 3);
        inj_dq5 = 0;
        hw_reset();
        chk(!fail && !busy, "R11", "reset clears fail", {fail, busy}, 0);

        // R7: stuck device, poll limit
        inj_stuck = 1;
        byte_q = '{8'h01};
        exp_std(11'h600, 8'h01);
        kick(11'h600, 1, 0);
        wait_done();
        chk(fail && fail_addr == 11'h600, "R7", "timeout fail addr", fail_addr, 11'h600);
        chk(rd_cnt == 1 + PM, "R7", "reads to timeout", rd_cnt, 1 + PM);
        inj_stuck = 0;
        hw_reset();

        // R11: reset mid-sequence, then the full sequence again
        sb_on = 0;
        byte_q = '{8'h3C, 8'h5A};
        begin
            int base = wr_cnt;
            kick(11'h300, 2, 0);
            while (wr_cnt < base + 2) @(negedge clk);
        end
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !fl_we && !fl_re, "R11", "idle under reset", {busy, fl_we, fl_re}, 0);
        rst_n = 1'b1;
        byte_q.delete(); exp_q.delete();
        @(negedge clk);
        chk(mem[11'h300] == 8'hFF, "R11", "interrupted byte unwritten", mem[11'h300], 8'hFF);
        sb_on = 1;
        byte_q = '{8'h3C};
        exp_std(11'h300, 8'h3C);
        kick(11'h300, 1, 0);
        wait_done();
        chk(!fail && mem[11'h300] == 8'h3C && exp_q.size() == 0, "R11",
            "reissued byte", mem[11'h300], 8'h3C);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule